// File: doc/BRIEF.md
# Conservative Load-Store Ordering Queue

This block keeps an ordered record of the memory operations in flight in an out-of-order core and decides, each cycle, whether a load may be sent to the data cache ahead of older stores. Every load and store gets an entry at the tail in program order. A store's address arrives later and separately from its data, so each store entry tracks whether its address is known. Committed operations retire from the head. A flush discards every entry younger than a chosen index.

A load asks for issue by presenting its queue index and address. It is granted only when every valid store older than it has a known address and none of those addresses matches the load's address. Only the low `CMP_W` address bits are stored and compared. Two different addresses that share those bits therefore block the load, which is safe. A blocked load sees a stall and may simply ask again in the next cycle.

Queue occupancy is tracked by a three-state machine:
- States: `Q_EMPTY`, `Q_PARTIAL`, `Q_FULL`.
- Transitions: `FIRST_ALLOC` (EMPTY to PARTIAL), `FILL` (PARTIAL to FULL), `DRAIN` (FULL to PARTIAL), `LAST_RETIRE` (PARTIAL to EMPTY) and `FLUSH_CUT`, where a flush sets the count directly and may land in any state.

Top module: `lsq_disambig`

## Requirements
- R1: After reset the queue is empty: `q_empty`=1, `q_full`=0, `alloc_idx`=0 and `ld_grant`=0.
- R2: While the queue is not full and no flush is active, `alloc_valid` writes an entry at index `alloc_idx`, and `alloc_idx` advances by one (mod DEPTH) at the next cycle. After DEPTH allocations without retirement `q_full`=1. While `q_full`=1, `alloc_valid` has no effect.
- R3: A load with no older valid store entry is granted in the same cycle as its request.
- R4: A load is stalled while any older valid store has no known address.
- R5: A load is granted when all older stores have known addresses whose low `CMP_W` bits differ from the load's low `CMP_W` bits.
- R6: A load is stalled when an older store's low `CMP_W` address bits equal the load's, even if the upper bits differ.
- R7: Stores younger than the load, in queue order from the head, never block it.
- R8: `commit_valid` on a non-empty queue retires the head entry, and a retired store no longer blocks any load.
- R9: `flush_valid` with flush index F on a non-empty queue removes every entry younger than F. At the next cycle `alloc_idx` = F+1, and any entry later re-allocated there starts with an unknown address.
- R10: Age is judged by distance from the head, so the ordering stays correct when indices wrap past DEPTH-1.
- R11: `ld_stall` = `ld_req` and not `ld_grant`. `ld_grant` is never 1 without `ld_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate an entry at the tail |
| alloc_is_store | input | 1 | The allocated entry is a store |
| alloc_idx | output | IDX_W | Index the next allocation takes |
| q_full | output | 1 | No free entry |
| q_empty | output | 1 | No valid entry |
| sta_valid | input | 1 | Store address write |
| sta_idx | input | IDX_W | Entry receiving the store address |
| sta_addr | input | ADDR_W | Store address |
| ld_req | input | 1 | Load asks to issue |
| ld_idx | input | IDX_W | Queue index of the requesting load |
| ld_addr | input | ADDR_W | Load address |
| ld_grant | output | 1 | Load may issue this cycle |
| ld_stall | output | 1 | Load was refused this cycle |
| commit_valid | input | 1 | Retire the head entry |
| flush_valid | input | 1 | Discard entries younger than flush_idx |
| flush_idx | input | IDX_W | Youngest entry kept by the flush |

## Verification
The bench uses the default build: DEPTH=16, ADDR_W=32 and CMP_W=12. This makes a full-queue fill and a head position of 15 reachable in a few dozen cycles, so an older store at index 15 and a younger load at index 0 test the wrap of the age comparison. The 12-bit compare width lets addresses such as 0x5100 and 0x100 alias, which checks the conservative block. A flush followed by re-allocation shows that discarded entries leave no stale address behind.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } q_state_e;
endpackage

// File: rtl/lsq_ctrl.sv
module lsq_ctrl
    import lsq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic             commit_valid,
    input  logic             flush_valid,
    input  logic [IDX_W-1:0] flush_idx,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic             do_alloc,
    output logic             do_commit,
    output logic             do_flush,
    output logic [IDX_W-1:0] fl_off,
    output logic             q_full,
    output logic             q_empty
);
    localparam int CNT_W = IDX_W + 1;

    q_state_e         state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;

    assign fl_off    = flush_idx - head;
    assign do_flush  = flush_valid & ~q_empty;
    assign do_commit = commit_valid & ~q_empty;
    assign do_alloc  = alloc_valid & ~q_full & ~do_flush;

    always_comb begin
        if (do_flush)
            cnt_n = CNT_W'(fl_off) + CNT_W'(1) - CNT_W'(do_commit);
        else
            cnt_n = cnt + CNT_W'(do_alloc) - CNT_W'(do_commit);
    end

    // next state: named transitions
    always_comb begin
        state_n = state;
        if (do_flush) begin
            // FLUSH_CUT
            if (cnt_n == '0)                 state_n = Q_EMPTY;
            else if (cnt_n == CNT_W'(DEPTH)) state_n = Q_FULL;
            else                             state_n = Q_PARTIAL;
        end else begin
            unique case (state)
                Q_EMPTY:   if (cnt_n != '0) state_n = Q_PARTIAL;              // FIRST_ALLOC
                Q_PARTIAL: begin
                    if (cnt_n == CNT_W'(DEPTH)) state_n = Q_FULL;           // FILL
                    else if (cnt_n == '0)       state_n = Q_EMPTY;          // LAST_RETIRE
                end
                Q_FULL:    if (cnt_n != CNT_W'(DEPTH)) state_n = Q_PARTIAL; // DRAIN
                default:   state_n = Q_EMPTY;
            endcase
        end
    end

    // state register and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= Q_EMPTY;
            cnt   <= '0;
            head  <= '0;
            tail  <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            if (do_commit) head <= head + IDX_W'(1);
            if (do_flush)      tail <= flush_idx + IDX_W'(1);
            else if (do_alloc) tail <= tail + IDX_W'(1);
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            Q_EMPTY:   begin q_empty = 1'b1; q_full = 1'b0; end
            Q_PARTIAL: begin q_empty = 1'b0; q_full = 1'b0; end
            Q_FULL:    begin q_empty = 1'b0; q_full = 1'b1; end
            default:   begin q_empty = 1'b1; q_full = 1'b0; end
        endcase
    end
endmodule

// File: rtl/lsq_entries.sv
module lsq_entries #(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int CMP_W = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [IDX_W-1:0]             head,
    input  logic [IDX_W-1:0]             tail,
    input  logic                         do_alloc,
    input  logic                         alloc_is_store,
    input  logic                         do_commit,
    input  logic                         do_flush,
    input  logic [IDX_W-1:0]             fl_off,
    input  logic                         sta_valid,
    input  logic [IDX_W-1:0]             sta_idx,
    input  logic [CMP_W-1:0]             sta_lo,
    output logic [DEPTH-1:0]             e_valid,
    output logic [DEPTH-1:0]             e_store,
    output logic [DEPTH-1:0]             e_known,
    output logic [DEPTH-1:0][CMP_W-1:0]  e_lo
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        localparam logic [IDX_W-1:0] MY = IDX_W'(i);
        logic [IDX_W-1:0] off;
        assign off = MY - head;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_valid[i] <= 1'b0;
                e_store[i] <= 1'b0;
                e_known[i] <= 1'b0;
                e_lo[i]    <= '0;
            end else begin
                if (do_flush && (off > fl_off))
                    e_valid[i] <= 1'b0;
                else if (do_commit && (head == MY))
                    e_valid[i] <= 1'b0;
                if (do_alloc && (tail == MY)) begin
                    e_valid[i] <= 1'b1;
                    e_store[i] <= alloc_is_store;
                    e_known[i] <= 1'b0;
                end
                if (sta_valid && (sta_idx == MY)) begin
                    e_known[i] <= 1'b1;
                    e_lo[i]    <= sta_lo;
                end
            end
        end
    end
endmodule

// File: rtl/lsq_age_check.sv
module lsq_age_check #(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int CMP_W = 12
) (
    input  logic [IDX_W-1:0]             head,
    input  logic                         ld_req,
    input  logic [IDX_W-1:0]             ld_idx,
    input  logic [CMP_W-1:0]             ld_lo,
    input  logic [DEPTH-1:0]             e_valid,
    input  logic [DEPTH-1:0]             e_store,
    input  logic [DEPTH-1:0]             e_known,
    input  logic [DEPTH-1:0][CMP_W-1:0]  e_lo,
    output logic                         ld_grant,
    output logic                         ld_stall
);
    logic [IDX_W-1:0] ld_off;
    logic [DEPTH-1:0] blocker;

    assign ld_off = ld_idx - head;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        logic [IDX_W-1:0] off;
        logic             older;
        assign off        = IDX_W'(i) - head;
        assign older      = e_valid[i] & e_store[i] & (off < ld_off);
        assign blocker[i] = older & (~e_known[i] | (e_lo[i] == ld_lo));
    end

    assign ld_grant = ld_req & ~(|blocker);
    assign ld_stall = ld_req & (|blocker);
endmodule

// File: rtl/lsq_disambig.sv
module lsq_disambig #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    parameter int CMP_W  = 12,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic              alloc_is_store,
    output logic [IDX_W-1:0]  alloc_idx,
    output logic              q_full,
    output logic              q_empty,
    input  logic              sta_valid,
    input  logic [IDX_W-1:0]  sta_idx,
    input  logic [ADDR_W-1:0] sta_addr,
    input  logic              ld_req,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_grant,
    output logic              ld_stall,
    input  logic              commit_valid,
    input  logic              flush_valid,
    input  logic [IDX_W-1:0]  flush_idx
);
    logic [IDX_W-1:0]            head, tail, fl_off;
    logic                        do_alloc, do_commit, do_flush;
    logic [DEPTH-1:0]            e_valid, e_store, e_known;
    logic [DEPTH-1:0][CMP_W-1:0] e_lo;
    logic                        unused_hi;

    assign unused_hi = ^{sta_addr[ADDR_W-1:CMP_W], ld_addr[ADDR_W-1:CMP_W]};
    assign alloc_idx = tail;

    lsq_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
        .clk, .rst_n, .alloc_valid, .commit_valid, .flush_valid, .flush_idx,
        .head, .tail, .do_alloc, .do_commit, .do_flush, .fl_off,
        .q_full, .q_empty
    );

    lsq_entries #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CMP_W(CMP_W)) u_ent (
        .clk, .rst_n, .head, .tail, .do_alloc, .alloc_is_store, .do_commit,
        .do_flush, .fl_off, .sta_valid, .sta_idx,
        .sta_lo(sta_addr[CMP_W-1:0]),
        .e_valid, .e_store, .e_known, .e_lo
    );

    lsq_age_check #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CMP_W(CMP_W)) u_age (
        .head, .ld_req, .ld_idx, .ld_lo(ld_addr[CMP_W-1:0]),
        .e_valid, .e_store, .e_known, .e_lo, .ld_grant, .ld_stall
    );
endmodule

// File: rtl/lsq_disambig_chk.sv
module lsq_disambig_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid,
    input logic [IDX_W-1:0] alloc_idx,
    input logic             q_full,
    input logic             q_empty,
    input logic             ld_req,
    input logic             ld_grant,
    input logic             ld_stall,
    input logic             commit_valid,
    input logic             flush_valid,
    input logic [IDX_W-1:0] flush_idx
);
    // R2
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_full && q_empty));
    // R2
    alloc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !q_full && !(flush_valid && !q_empty))
        |=> alloc_idx == IDX_W'($past(alloc_idx) + 1'b1));
    // R2
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && alloc_valid && !commit_valid && !flush_valid)
        |=> ($stable(alloc_idx) && q_full));
    // R9
    flush_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && !q_empty) |=> alloc_idx == IDX_W'($past(flush_idx) + 1'b1));
    // R11
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_grant |-> ld_req);
    // R11
    stall_grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req |-> (ld_grant != ld_stall));
endmodule

bind lsq_disambig lsq_disambig_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_idx(alloc_idx),
    .q_full(q_full), .q_empty(q_empty), .ld_req(ld_req), .ld_grant(ld_grant),
    .ld_stall(ld_stall), .commit_valid(commit_valid), .flush_valid(flush_valid),
    .flush_idx(flush_idx)
);

// File: tb/lsq_disambig_tb.sv
`timescale 1ns/1ps
module lsq_disambig_tb;
    localparam int DEPTH = 16, ADDR_W = 32, CMP_W = 12, IDX_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_valid = 1'b0, alloc_is_store = 1'b0;
    logic [IDX_W-1:0]  alloc_idx;
    logic              q_full, q_empty;
    logic              sta_valid = 1'b0;
    logic [IDX_W-1:0]  sta_idx = '0;
    logic [ADDR_W-1:0] sta_addr = '0;
    logic              ld_req = 1'b0;
    logic [IDX_W-1:0]  ld_idx = '0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic              ld_grant, ld_stall;
    logic              commit_valid = 1'b0, flush_valid = 1'b0;
    logic [IDX_W-1:0]  flush_idx = '0;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lsq_disambig #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CMP_W(CMP_W)) u_dut (.*);

    // probe vectors {ld_idx, ld_addr, expected grant}
    localparam logic [36:0] VEC [6] = '{
        {4'd1, 32'h0000_0200, 1'b1},   // R5 R7: store0 differs, stores 2 and 4 younger
        {4'd1, 32'h0000_5100, 1'b0},   // R6: aliases store0 (0x100)
        {4'd3, 32'h0000_0300, 1'b1},   // R5: stores 0 and 2 known, differ
        {4'd3, 32'h0000_1200, 1'b0},   // R6: aliases store2 (0x200)
        {4'd5, 32'h0000_0300, 1'b0},   // R4: store4 address unknown
        {4'd0, 32'h0000_0100, 1'b1}    // R3: nothing older than head
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reset_dut();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic alloc(input bit st);
        @(negedge clk); alloc_valid = 1'b1; alloc_is_store = st;
        @(negedge clk); alloc_valid = 1'b0;
    endtask

    task automatic sta(input logic [IDX_W-1:0] i, input logic [ADDR_W-1:0] a);
        @(negedge clk); sta_valid = 1'b1; sta_idx = i; sta_addr = a;
        @(negedge clk); sta_valid = 1'b0;
    endtask

    task automatic commit1();
        @(negedge clk); commit_valid = 1'b1;
        @(negedge clk); commit_valid = 1'b0;
    endtask

    task automatic flush(input logic [IDX_W-1:0] i);
        @(negedge clk); flush_valid = 1'b1; flush_idx = i;
        @(negedge clk); flush_valid = 1'b0;
    endtask

    task automatic probe(input logic [IDX_W-1:0] i, input logic [ADDR_W-1:0] a,
                         input bit exp, input string req);
        @(negedge clk); ld_req = 1'b1; ld_idx = i; ld_addr = a;
        #1;
        check(ld_grant == exp, req, ld_grant, exp);
        check(ld_stall == !exp, {req, " R11 stall"}, ld_stall, !exp);
        ld_req = 1'b0;
    endtask

    initial begin
        reset_dut();
        #1;
        // R1
        check(q_empty == 1'b1, "R1 empty", q_empty, 1);
        check(q_full == 1'b0, "R1 full", q_full, 0);
        check(alloc_idx == 0, "R1 alloc_idx", alloc_idx, 0);
        check(ld_grant == 1'b0, "R1 R11 grant idle", ld_grant, 0);

        // program order: S L S L S L at indices 0..5
        for (int k = 0; k < 6; k++) alloc(k % 2 == 0);
        check(alloc_idx == 6, "R2 alloc_idx", alloc_idx, 6);
        check(q_empty == 1'b0, "R2 not empty", q_empty, 0);
        sta(0, 32'h0000_0100);
        sta(2, 32'h0007_0200);

        for (int v = 0; v < 6; v++)
            probe(VEC[v][36:33], VEC[v][32:1], VEC[v][0], $sformatf("vec%0d", v));

        sta(4, 32'h0000_0400);
        probe(5, 32'h0000_0300, 1'b1, "R5 all known");
        probe(5, 32'h0000_0400, 1'b0, "R6 exact match");

        commit1();
        probe(1, 32'h0000_0100, 1'b1, "R8 retired store");

        flush(3);
        check(alloc_idx == 4, "R9 tail after flush", alloc_idx, 4);
        alloc(1'b1);
        alloc(1'b0);
        probe(5, 32'h0000_0900, 1'b0, "R9 realloc unknown");
        check(alloc_idx == 6, "R9 alloc_idx", alloc_idx, 6);

        // wrap test
        reset_dut();
        for (int k = 0; k < DEPTH; k++) alloc(k == DEPTH - 1);
        #1;
        check(q_full == 1'b1, "R2 full", q_full, 1);
        alloc(1'b0);
        check(q_full == 1'b1, "R2 still full", q_full, 1);
        commit1();
        check(q_full == 1'b0, "R2 drained", q_full, 0);
        check(alloc_idx == 0, "R2 ignored alloc", alloc_idx, 0);
        for (int k = 0; k < DEPTH - 2; k++) commit1();
        alloc(1'b0);
        check(alloc_idx == 1, "R10 alloc wrap", alloc_idx, 1);
        probe(0, 32'h0000_00AC, 1'b0, "R10 older unknown across wrap");
        sta(15, 32'h0000_00AB);
        probe(0, 32'h0000_00AC, 1'b1, "R10 older known across wrap");
        probe(0, 32'h0000_10AB, 1'b0, "R10 R6 alias across wrap");
        commit1();
        probe(0, 32'h0000_00AB, 1'b1, "R8 R3 head load");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule